// File: doc/BRIEF.md
# Dual Threshold Alarm Trigger Unit

This block watches a stream of sensor samples with two alarm channels that work independently of each other. Each channel is pointed at one sample source by a 4-bit code: supply level, X, Y or Z acceleration, auxiliary converter, temperature, or the peak sum-of-squares word. A channel can also be pointed at an external comparator flag. A sample source is reduced to an unsigned magnitude and compared against a 14-bit threshold magnitude, in the direction that the threshold word sets. Acceleration sources are two's complement, so their absolute value is used.

A channel whose alarm condition becomes true can request a data capture with a single-cycle pulse. It also sets a sticky status bit, which stays set until the status word is read. The live conditions of both channels drive an alarm indicator. The indicator can be enabled, its polarity can be chosen, and it can be routed to either of two output pins. The block also computes the reference level for the external comparators from a 4-bit level code and the current supply sample. While the system is in standby, an externally triggered capture raises a wake request.

Top module: `alarm_trigger_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is 0 after that edge.
- R2: Source codes: 1 is supply, 2, 3 and 4 are X, Y and Z acceleration, 5 is auxiliary, 6 is temperature, 7 is peak. For acceleration, the magnitude is the absolute value of the ACC_W-bit two's-complement sample, so -512 gives 512. `alarm_active` reflects a `sample_valid` cycle one clock edge later.
- R3: The threshold word carries the direction in bit 15 and the magnitude in bits 13:0. Bit 15 = 1 raises the alarm when magnitude > threshold, and bit 15 = 0 raises it when magnitude < threshold. A magnitude equal to the threshold never raises the alarm, and bit 14 has no effect.
- R4: Code 0 and codes 9 to 15 disable a channel. Its condition is cleared at the next `sample_valid` and the channel never raises an alarm.
- R5: `capture_req[k]` is a one-cycle pulse, raised when channel k's condition goes from false to true while `cap_en[k]` is 1. A condition that stays true does not pulse again.
- R6: `alarm_status[k]` is set whenever channel k evaluates true. It stays set until a cycle with `status_rd` high and no new hit on that channel. A hit in the same cycle as a read wins.
- R7: When `ind_en` is 0, both indicator pins are 0. When `ind_en` is 1, the pin chosen by `ind_pin_sel` (0 = `ind_pin_a`, 1 = `ind_pin_b`) is driven and the other pin is 0. The driven level is the OR of both channel conditions, inverted when `ind_pol` is 0. The indicator follows configuration changes one cycle later, without needing a sample.
- R8: Code 8 selects the external source. For channel k, the condition is `ext_en[k]` AND (`ext_cmp[k]` when `ext_dir[k]` is 1, otherwise NOT `ext_cmp[k]`). This condition is evaluated on every clock cycle, whether or not `sample_valid` is high.
- R9: `wake_req` pulses in the same cycle as a capture pulse that comes from an external-source channel, provided `standby` was high at that edge. It is never high otherwise.
- R10: On each `sample_valid` cycle, `ext_level` is loaded with floor(`ext_tl` × `supply_in` / 24).
- R11: Between `sample_valid` cycles, a channel on a sample source keeps its condition, even if its input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | New sample set present on the sample inputs |
| supply_in | input | UNS_W | Supply level sample, unsigned |
| acc_x_in | input | ACC_W | X acceleration, two's complement |
| acc_y_in | input | ACC_W | Y acceleration, two's complement |
| acc_z_in | input | ACC_W | Z acceleration, two's complement |
| aux_in | input | UNS_W | Auxiliary converter sample, unsigned |
| temp_in | input | UNS_W | Temperature sample, unsigned |
| peak_in | input | UNS_W | Peak sum-of-squares sample, unsigned |
| ext_cmp | input | 2 | External comparator flags, bit k for channel k |
| standby | input | 1 | System is in standby |
| src_sel_a | input | 4 | Source code of channel 0 |
| src_sel_b | input | 4 | Source code of channel 1 |
| thr_a | input | 16 | Threshold word of channel 0 |
| thr_b | input | 16 | Threshold word of channel 1 |
| cap_en | input | 2 | Capture request enable per channel |
| ext_en | input | 2 | External trigger enable per channel |
| ext_dir | input | 2 | External trigger direction per channel (1 = flag high) |
| ext_tl | input | TL_W | External trigger level code |
| ind_en | input | 1 | Indicator enable |
| ind_pol | input | 1 | Indicator polarity (1 = active high) |
| ind_pin_sel | input | 1 | Indicator pin choice (0 = a, 1 = b) |
| status_rd | input | 1 | Status word read strobe |
| capture_req | output | 2 | Capture request pulses |
| alarm_status | output | 2 | Sticky alarm flags |
| alarm_active | output | 2 | Current alarm conditions |
| ind_pin_a | output | 1 | Indicator pin a |
| ind_pin_b | output | 1 | Indicator pin b |
| wake_req | output | 1 | Wake request pulse |
| ext_level | output | UNS_W | External comparator reference level |

## Verification
All outputs are registered, so every result is due exactly one rising edge after the stimulus edge. This covers a sample strobe, an external flag change, a configuration change and a status read alike. The bench drives inputs on the falling edge and samples on the next falling edge, which falls between the result edge and the one after it. That sampling point is where a one-cycle capture or wake pulse must be seen high. The following falling edge confirms that the pulse has dropped and that a held condition does not trigger again.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_CH  = 2;
  localparam int THR_W   = 16;
  localparam int MAG_W   = 14;
  localparam int DIR_BIT = 15;
  localparam int SEL_W   = 4;

  typedef enum logic [SEL_W-1:0] {
    SRC_OFF    = 4'd0,
    SRC_SUPPLY = 4'd1,
    SRC_ACC_X  = 4'd2,
    SRC_ACC_Y  = 4'd3,
    SRC_ACC_Z  = 4'd4,
    SRC_AUX    = 4'd5,
    SRC_TEMP   = 4'd6,
    SRC_PEAK   = 4'd7,
    SRC_EXT    = 4'd8
  } src_sel_e;
endpackage

// File: rtl/alarm_source_mux.sv
module alarm_source_mux
  import alarm_pkg::*;
#(
  parameter int ACC_W = 10,
  parameter int UNS_W = 12
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [UNS_W-1:0] supply_i,
  input  logic [ACC_W-1:0] acc_x_i,
  input  logic [ACC_W-1:0] acc_y_i,
  input  logic [ACC_W-1:0] acc_z_i,
  input  logic [UNS_W-1:0] aux_i,
  input  logic [UNS_W-1:0] temp_i,
  input  logic [UNS_W-1:0] peak_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             active_o,
  output logic             is_ext_o
);
  localparam logic [ACC_W-1:0] ACC_ONE = ACC_W'(1);

  // Absolute value of a two's-complement acceleration word, zero-extended.
  function automatic logic [MAG_W-1:0] abs_mag(input logic [ACC_W-1:0] v);
    logic [ACC_W-1:0] n;
    n = v[ACC_W-1] ? (~v + ACC_ONE) : v;
    return MAG_W'(n);
  endfunction

  always_comb begin
    mag_o    = '0;
    active_o = 1'b1;
    is_ext_o = 1'b0;
    case (src_sel_e'(sel_i))
      SRC_SUPPLY: mag_o = MAG_W'(supply_i);
      SRC_ACC_X:  mag_o = abs_mag(acc_x_i);
      SRC_ACC_Y:  mag_o = abs_mag(acc_y_i);
      SRC_ACC_Z:  mag_o = abs_mag(acc_z_i);
      SRC_AUX:    mag_o = MAG_W'(aux_i);
      SRC_TEMP:   mag_o = MAG_W'(temp_i);
      SRC_PEAK:   mag_o = MAG_W'(peak_i);
      SRC_EXT: begin
        active_o = 1'b0;
        is_ext_o = 1'b1;
      end
      default:    active_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel
  import alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             eval_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             active_i,
  input  logic             is_ext_i,
  input  logic             dir_gt_i,
  input  logic [MAG_W-1:0] thr_mag_i,
  input  logic             ext_hit_i,
  input  logic             cap_en_i,
  input  logic             status_clr_i,
  output logic             cond_o,
  output logic             cond_next_o,
  output logic             cap_next_o,
  output logic             cap_pulse_o,
  output logic             status_o
);
  logic cond_q, cap_q, status_q;
  logic upd, cmp_hit, hit;

  assign upd     = eval_i | is_ext_i;
  assign cmp_hit = dir_gt_i ? (mag_i > thr_mag_i) : (mag_i < thr_mag_i);
  assign hit     = is_ext_i ? ext_hit_i : (active_i & cmp_hit);

  assign cond_next_o = upd ? hit : cond_q;
  assign cap_next_o  = cap_en_i & cond_next_o & ~cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q   <= 1'b0;
      cap_q    <= 1'b0;
      status_q <= 1'b0;
    end else begin
      cond_q <= cond_next_o;
      cap_q  <= cap_next_o;
      if (upd && hit)
        status_q <= 1'b1;
      else if (status_clr_i)
        status_q <= 1'b0;
    end
  end

  assign cond_o      = cond_q;
  assign cap_pulse_o = cap_q;
  assign status_o    = status_q;
endmodule

// File: rtl/alarm_indicator.sv
module alarm_indicator
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cond_i,
  input  logic              en_i,
  input  logic              pol_i,
  input  logic              pin_sel_i,
  output logic              pin_a_o,
  output logic              pin_b_o
);
  logic any_cond, level;
  logic pin_a_q, pin_b_q;

  assign any_cond = |cond_i;
  assign level    = pol_i ? any_cond : ~any_cond;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_a_q <= 1'b0;
      pin_b_q <= 1'b0;
    end else begin
      pin_a_q <= en_i & ~pin_sel_i & level;
      pin_b_q <= en_i &  pin_sel_i & level;
    end
  end

  assign pin_a_o = pin_a_q;
  assign pin_b_o = pin_b_q;
endmodule

// File: rtl/alarm_trigger_unit.sv
module alarm_trigger_unit
  import alarm_pkg::*;
#(
  parameter int ACC_W   = 10,
  parameter int UNS_W   = 12,
  parameter int TL_W    = 4,
  parameter int EXT_DIV = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid,
  input  logic [UNS_W-1:0]  supply_in,
  input  logic [ACC_W-1:0]  acc_x_in,
  input  logic [ACC_W-1:0]  acc_y_in,
  input  logic [ACC_W-1:0]  acc_z_in,
  input  logic [UNS_W-1:0]  aux_in,
  input  logic [UNS_W-1:0]  temp_in,
  input  logic [UNS_W-1:0]  peak_in,
  input  logic [1:0]        ext_cmp,
  input  logic              standby,
  input  logic [3:0]        src_sel_a,
  input  logic [3:0]        src_sel_b,
  input  logic [15:0]       thr_a,
  input  logic [15:0]       thr_b,
  input  logic [1:0]        cap_en,
  input  logic [1:0]        ext_en,
  input  logic [1:0]        ext_dir,
  input  logic [TL_W-1:0]   ext_tl,
  input  logic              ind_en,
  input  logic              ind_pol,
  input  logic              ind_pin_sel,
  input  logic              status_rd,
  output logic [1:0]        capture_req,
  output logic [1:0]        alarm_status,
  output logic [1:0]        alarm_active,
  output logic              ind_pin_a,
  output logic              ind_pin_b,
  output logic              wake_req,
  output logic [UNS_W-1:0]  ext_level
);
  localparam int PROD_W = UNS_W + TL_W;

  logic [SEL_W-1:0]  sel_arr [NUM_CH];
  logic [THR_W-1:0]  thr_arr [NUM_CH];
  logic [MAG_W-1:0]  mag     [NUM_CH];
  logic [NUM_CH-1:0] src_act, is_ext, ext_hit;
  logic [NUM_CH-1:0] cond_q, cond_next, cap_next, cap_q, status_q;
  logic              unused_thr_spare;

  assign sel_arr[0] = src_sel_a;
  assign sel_arr[1] = src_sel_b;
  assign thr_arr[0] = thr_a;
  assign thr_arr[1] = thr_b;
  assign unused_thr_spare = thr_a[14] ^ thr_b[14];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    alarm_source_mux #(.ACC_W(ACC_W), .UNS_W(UNS_W)) u_mux (
      .sel_i    (sel_arr[k]),
      .supply_i (supply_in),
      .acc_x_i  (acc_x_in),
      .acc_y_i  (acc_y_in),
      .acc_z_i  (acc_z_in),
      .aux_i    (aux_in),
      .temp_i   (temp_in),
      .peak_i   (peak_in),
      .mag_o    (mag[k]),
      .active_o (src_act[k]),
      .is_ext_o (is_ext[k])
    );

    assign ext_hit[k] = ext_en[k] & (ext_dir[k] ? ext_cmp[k] : ~ext_cmp[k]);

    alarm_channel u_ch (
      .clk          (clk),
      .rst          (rst),
      .eval_i       (sample_valid),
      .mag_i        (mag[k]),
      .active_i     (src_act[k]),
      .is_ext_i     (is_ext[k]),
      .dir_gt_i     (thr_arr[k][DIR_BIT]),
      .thr_mag_i    (thr_arr[k][MAG_W-1:0]),
      .ext_hit_i    (ext_hit[k]),
      .cap_en_i     (cap_en[k]),
      .status_clr_i (status_rd),
      .cond_o       (cond_q[k]),
      .cond_next_o  (cond_next[k]),
      .cap_next_o   (cap_next[k]),
      .cap_pulse_o  (cap_q[k]),
      .status_o     (status_q[k])
    );
  end

  alarm_indicator u_ind (
    .clk       (clk),
    .rst       (rst),
    .cond_i    (cond_next),
    .en_i      (ind_en),
    .pol_i     (ind_pol),
    .pin_sel_i (ind_pin_sel),
    .pin_a_o   (ind_pin_a),
    .pin_b_o   (ind_pin_b)
  );

  // Wake on an externally sourced capture while in standby.
  logic wake_q;
  always_ff @(posedge clk) begin
    if (rst) wake_q <= 1'b0;
    else     wake_q <= standby & |(cap_next & is_ext);
  end

  // Comparator reference: level code times supply over the fixed divisor.
  logic [PROD_W-1:0] level_prod, level_quot;
  logic [UNS_W-1:0]  level_q;
  assign level_prod = PROD_W'(ext_tl) * PROD_W'(supply_in);
  assign level_quot = level_prod / PROD_W'(EXT_DIV);

  always_ff @(posedge clk) begin
    if (rst)               level_q <= '0;
    else if (sample_valid) level_q <= UNS_W'(level_quot);
  end

  assign capture_req  = cap_q;
  assign alarm_status = status_q;
  assign alarm_active = cond_q;
  assign wake_req     = wake_q;
  assign ext_level    = level_q;
endmodule

// File: rtl/alarm_trigger_checker.sv
module alarm_trigger_checker (
  input logic       clk,
  input logic       rst,
  input logic       sample_valid,
  input logic       standby,
  input logic       status_rd,
  input logic [3:0] src_sel_a,
  input logic [3:0] src_sel_b,
  input logic [1:0] cap_en,
  input logic [1:0] capture_req,
  input logic [1:0] alarm_status,
  input logic [1:0] alarm_active,
  input logic       ind_pin_a,
  input logic       ind_pin_b,
  input logic       wake_req
);
  logic [3:0] sel_c [2];
  assign sel_c[0] = src_sel_a;
  assign sel_c[1] = src_sel_b;

  for (genvar k = 0; k < 2; k++) begin : g_chk
    assert_cap_single_R5: assert property (@(posedge clk) disable iff (rst)
      capture_req[k] |=> !capture_req[k]);
    assert_cap_enabled_R5: assert property (@(posedge clk) disable iff (rst)
      capture_req[k] |-> $past(cap_en[k]));
    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (alarm_status[k] && !status_rd) |=> alarm_status[k]);
    assert_status_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(alarm_active[k]) |-> alarm_status[k]);
    assert_off_quiet_R4: assert property (@(posedge clk) disable iff (rst)
      (sel_c[k] == 4'd0 && sample_valid) |=> !alarm_active[k]);
  end

  assert_ind_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ind_pin_a, ind_pin_b}));
  assert_wake_standby_R9: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(standby));
endmodule

bind alarm_trigger_unit alarm_trigger_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .sample_valid (sample_valid),
  .standby      (standby),
  .status_rd    (status_rd),
  .src_sel_a    (src_sel_a),
  .src_sel_b    (src_sel_b),
  .cap_en       (cap_en),
  .capture_req  (capture_req),
  .alarm_status (alarm_status),
  .alarm_active (alarm_active),
  .ind_pin_a    (ind_pin_a),
  .ind_pin_b    (ind_pin_b),
  .wake_req     (wake_req)
);

// File: tb/alarm_trigger_unit_bench.sv
module alarm_trigger_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W = 10;
  localparam int UNS_W = 12;
  localparam int TL_W  = 4;

  logic clk = 1'b0;
  logic rst;
  logic sample_valid;
  logic [UNS_W-1:0] supply_in, aux_in, temp_in, peak_in;
  logic [ACC_W-1:0] acc_x_in, acc_y_in, acc_z_in;
  logic [1:0] ext_cmp, cap_en, ext_en, ext_dir;
  logic standby, ind_en, ind_pol, ind_pin_sel, status_rd;
  logic [3:0] src_sel_a, src_sel_b;
  logic [15:0] thr_a, thr_b;
  logic [TL_W-1:0] ext_tl;
  logic [1:0] capture_req, alarm_status, alarm_active;
  logic ind_pin_a, ind_pin_b, wake_req;
  logic [UNS_W-1:0] ext_level;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_trigger_unit u_alarm_trigger_unit (
    .clk(clk), .rst(rst), .sample_valid(sample_valid),
    .supply_in(supply_in), .acc_x_in(acc_x_in), .acc_y_in(acc_y_in),
    .acc_z_in(acc_z_in), .aux_in(aux_in), .temp_in(temp_in), .peak_in(peak_in),
    .ext_cmp(ext_cmp), .standby(standby), .src_sel_a(src_sel_a),
    .src_sel_b(src_sel_b), .thr_a(thr_a), .thr_b(thr_b), .cap_en(cap_en),
    .ext_en(ext_en), .ext_dir(ext_dir), .ext_tl(ext_tl), .ind_en(ind_en),
    .ind_pol(ind_pol), .ind_pin_sel(ind_pin_sel), .status_rd(status_rd),
    .capture_req(capture_req), .alarm_status(alarm_status),
    .alarm_active(alarm_active), .ind_pin_a(ind_pin_a), .ind_pin_b(ind_pin_b),
    .wake_req(wake_req), .ext_level(ext_level)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic zero_inputs();
    sample_valid = 0; supply_in = 0; aux_in = 0; temp_in = 0; peak_in = 0;
    acc_x_in = 0; acc_y_in = 0; acc_z_in = 0; ext_cmp = 0; standby = 0;
    src_sel_a = 0; src_sel_b = 0; thr_a = 0; thr_b = 0; cap_en = 0;
    ext_en = 0; ext_dir = 0; ext_tl = 0; ind_en = 0; ind_pol = 0;
    ind_pin_sel = 0; status_rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    zero_inputs();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  // One sample strobe; returns at the falling edge after the result edge.
  task automatic strobe();
    sample_valid = 1;
    @(negedge clk);
    sample_valid = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_code_inputs(input int code, input int tgt, input int oth);
    supply_in = UNS_W'((code == 1) ? tgt : oth);
    acc_x_in  = ACC_W'((code == 2) ? tgt : oth);
    acc_y_in  = ACC_W'((code == 3) ? tgt : oth);
    acc_z_in  = ACC_W'((code == 4) ? tgt : oth);
    aux_in    = UNS_W'((code == 5) ? tgt : oth);
    temp_in   = UNS_W'((code == 6) ? tgt : oth);
    peak_in   = UNS_W'((code == 7) ? tgt : oth);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1;
    supply_in = 100; src_sel_a = 1; thr_a = 16'h8000 | 16'd10;
    cap_en = 2'b11; ind_en = 1; ind_pol = 0; ext_tl = 4'd5; sample_valid = 1;
    repeat (2) @(negedge clk);
    check("R1", "capture_req", 32'(capture_req), 0);
    check("R1", "alarm_active", 32'(alarm_active), 0);
    check("R1", "alarm_status", 32'(alarm_status), 0);
    check("R1", "ind pins", 32'({ind_pin_a, ind_pin_b}), 0);
    check("R1", "wake/level", 32'({wake_req, ext_level}), 0);
    zero_inputs();
    rst = 0;
  endtask

  task automatic t_source_codes();
    do_reset();
    thr_a = 16'h8000 | 16'd50;
    for (int c = 1; c <= 7; c++) begin
      src_sel_a = 4'(c);
      set_code_inputs(c, 100, 0);
      strobe();
      check("R2", $sformatf("code %0d selected input", c), 32'(alarm_active[0]), 1);
      set_code_inputs(c, 0, 100);
      strobe();
      check("R2", $sformatf("code %0d other inputs", c), 32'(alarm_active[0]), 0);
    end
  endtask

  task automatic t_accel_abs();
    do_reset();
    src_sel_a = 2; thr_a = 16'h8000 | 16'd5; cap_en = 2'b01;
    acc_x_in = -10'sd7;
    strobe();
    check("R2", "abs(-7)>5 active", 32'(alarm_active[0]), 1);
    check("R5", "capture pulse on rise", 32'(capture_req[0]), 1);
    step();
    check("R5", "capture pulse one cycle", 32'(capture_req[0]), 0);
    strobe();
    check("R5", "held alarm no retrigger", 32'(capture_req[0]), 0);
    check("R5", "held alarm still active", 32'(alarm_active[0]), 1);
    acc_x_in = -10'sd5;
    strobe();
    check("R3", "equal magnitude no alarm", 32'(alarm_active[0]), 0);
    acc_x_in = 10'h200;
    strobe();
    check("R2", "abs(-512) active", 32'(alarm_active[0]), 1);
    check("R5", "capture on second rise", 32'(capture_req[0]), 1);
    cap_en = 2'b00;
    acc_x_in = 0;
    strobe();
    acc_x_in = 10'd9;
    strobe();
    check("R5", "disabled capture", 32'(capture_req[0]), 0);
  endtask

  task automatic t_less();
    do_reset();
    src_sel_b = 6; thr_b = 16'h4000 | 16'd300;
    temp_in = 299;
    strobe();
    check("R3", "less 299<300 (bit14 ignored)", 32'(alarm_active[1]), 1);
    temp_in = 300;
    strobe();
    check("R3", "less equal none", 32'(alarm_active[1]), 0);
    temp_in = 301;
    strobe();
    check("R3", "less 301 none", 32'(alarm_active[1]), 0);
  endtask

  task automatic t_disabled();
    do_reset();
    src_sel_a = 1; thr_a = 16'h8000; supply_in = 12'hFFF;
    strobe();
    check("R4", "precondition active", 32'(alarm_active[0]), 1);
    src_sel_a = 0;
    strobe();
    check("R4", "code 0 clears", 32'(alarm_active[0]), 0);
    foreach (thr_b[i]) begin end
    src_sel_a = 9; set_code_inputs(0, 0, 300);
    strobe();
    check("R4", "code 9 no alarm", 32'(alarm_active[0]), 0);
    src_sel_a = 15;
    strobe();
    check("R4", "code 15 no alarm", 32'(alarm_active[0]), 0);
  endtask

  task automatic t_hold();
    do_reset();
    src_sel_a = 1; thr_a = 16'h8000 | 16'd10; supply_in = 100; cap_en = 2'b01;
    strobe();
    supply_in = 5;
    repeat (3) step();
    check("R11", "condition held without strobe", 32'(alarm_active[0]), 1);
    check("R11", "no capture without strobe", 32'(capture_req[0]), 0);
  endtask

  task automatic t_status();
    do_reset();
    src_sel_a = 1; thr_a = 16'h8000 | 16'd10; supply_in = 100;
    strobe();
    check("R6", "status set", 32'(alarm_status[0]), 1);
    supply_in = 5;
    strobe();
    check("R6", "status sticky", 32'(alarm_status[0]), 1);
    status_rd = 1;
    step();
    status_rd = 0;
    check("R6", "status cleared by read", 32'(alarm_status[0]), 0);
    supply_in = 100; status_rd = 1;
    strobe();
    status_rd = 0;
    check("R6", "hit wins over read", 32'(alarm_status[0]), 1);
  endtask

  task automatic t_indicator();
    do_reset();
    src_sel_a = 1; thr_a = 16'h8000 | 16'd10; supply_in = 100;
    ind_en = 1; ind_pol = 1; ind_pin_sel = 0;
    strobe();
    check("R7", "pin a active high", 32'({ind_pin_a, ind_pin_b}), 2'b10);
    ind_pin_sel = 1;
    step();
    check("R7", "moved to pin b", 32'({ind_pin_a, ind_pin_b}), 2'b01);
    ind_pol = 0;
    step();
    check("R7", "negative polarity active", 32'({ind_pin_a, ind_pin_b}), 2'b00);
    supply_in = 5;
    strobe();
    check("R7", "negative polarity idle", 32'({ind_pin_a, ind_pin_b}), 2'b01);
    src_sel_b = 6; thr_b = 16'h8000 | 16'd10; temp_in = 50; ind_pol = 1;
    strobe();
    check("R7", "OR of channels via b", 32'({ind_pin_a, ind_pin_b}), 2'b01);
    ind_en = 0;
    step();
    check("R7", "disabled both low", 32'({ind_pin_a, ind_pin_b}), 2'b00);
  endtask

  task automatic t_external();
    do_reset();
    src_sel_a = 8; ext_en = 2'b01; ext_dir = 2'b01; cap_en = 2'b01;
    step();
    check("R8", "flag low, greater dir", 32'(alarm_active[0]), 0);
    ext_cmp = 2'b01;
    step();
    check("R8", "flag high no strobe", 32'(alarm_active[0]), 1);
    check("R8", "ext capture pulse", 32'(capture_req[0]), 1);
    check("R9", "no wake when awake", 32'(wake_req), 0);
    step();
    check("R8", "ext capture one cycle", 32'(capture_req[0]), 0);
    ext_cmp = 2'b00;
    step();
    check("R8", "flag dropped", 32'(alarm_active[0]), 0);
    standby = 1; ext_cmp = 2'b01;
    step();
    check("R9", "wake in standby", 32'(wake_req), 1);
    check("R9", "capture in standby", 32'(capture_req[0]), 1);
    step();
    check("R9", "wake one cycle", 32'(wake_req), 0);
    standby = 0; ext_dir = 2'b00;
    step();
    check("R8", "less dir flag high", 32'(alarm_active[0]), 0);
    ext_cmp = 2'b00;
    step();
    check("R8", "less dir flag low", 32'(alarm_active[0]), 1);
    ext_en = 2'b00;
    step();
    check("R8", "ext disabled", 32'(alarm_active[0]), 0);
    src_sel_b = 8; ext_en = 2'b10; ext_dir = 2'b10; ext_cmp = 2'b10;
    step();
    check("R8", "channel b uses its flag", 32'(alarm_active), 2'b10);
  endtask

  task automatic t_level();
    do_reset();
    ext_tl = 12; supply_in = 2000;
    strobe();
    check("R10", "12*2000/24", 32'(ext_level), 1000);
    ext_tl = 15; supply_in = 4095;
    strobe();
    check("R10", "15*4095/24 floor", 32'(ext_level), 2559);
    ext_tl = 0;
    step();
    check("R10", "held without strobe", 32'(ext_level), 2559);
    strobe();
    check("R10", "zero level", 32'(ext_level), 0);
  endtask

  initial begin
    zero_inputs();
    rst = 1;
    t_reset();
    t_source_codes();
    t_accel_abs();
    t_less();
    t_disabled();
    t_hold();
    t_status();
    t_indicator();
    t_external();
    t_level();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule